// File: doc/BRIEF.md
# Greedy-then-youngest warp issue selector

This block chooses, once per clock, which warp of a sub-core issues its oldest buffered instruction. It looks at a few inputs for each warp: whether an instruction is present, whether an external dependence tracker reports the instruction free of hazards, two compiler-written control fields (a stall count and a yield hint), the execution unit the instruction targets and how wide that unit is, and whether the instruction's constant operand hit in the constant cache. It drives a one-hot grant and the index of the granted warp. No more than one warp is granted in a cycle.

The policy is greedy. The warp that issued last keeps the slot for as long as it stays eligible. When that warp drops out, the slot goes to the youngest eligible warp, meaning the one with the highest index. The block keeps its own state for this: a stall countdown and a one-cycle yield block for each warp, a hold flag on each execution unit's input latch, the last-issued warp, and a counter of cycles spent waiting on a constant-cache miss. When the wait reaches its limit, the block gives the slot to another ready warp.

Top module: `gty_issue_select`

## Requirements
- R1: At most one bit of `grant_o` is set. `grant_vld_o` is high exactly when one bit is set, and in that case `grant_idx_o` is the index of that bit. When nothing issues, `grant_idx_o` is 0.
- R2: A warp can be granted only when its `inst_vld_i` bit and its `dep_rdy_i` bit are both high.
- R3: If the last granted warp is still ready and hits in the constant cache, it is granted again, even when a younger warp is also ready.
- R4: When the last granted warp is not ready, the grant goes to the ready warp with the highest index. After reset no warp counts as last granted, so the first grant also goes to the highest-index ready warp.
- R5: A warp granted with a 4-bit stall field of S ≥ 2 cannot be granted again until S cycles after that grant. With S of 0 or 1 it can be granted in the very next cycle.
- R6: A warp granted with its yield bit set and a stall field of 0 or 1 cannot be granted in the next cycle. If no other warp is ready in that cycle, nothing issues.
- R7: When the stall field is 2 or more, the yield bit changes nothing. The warp's next grant comes at the same cycle it would come with yield clear.
- R8: Each warp selects a unit with a 2-bit code and a width class: 1 means half-warp wide, 0 means full-warp wide. A grant to a half-wide unit makes that unit's input latch busy for the next cycle, and no warp targeting that unit is ready in that cycle. A grant to a full-wide unit blocks nothing.
- R9: If the warp picked by R3/R4 has `cc_hit_i` low, nothing issues. This lasts for up to four consecutive cycles of waiting on that same warp.
- R10: On the fifth consecutive cycle in which that same warp is still picked and still missing, the grant goes to the highest-index ready warp other than it that has `cc_hit_i` high. If no such warp exists, nothing issues.
- R11: While `rst_n` is low, and after reset before any grant, all stall countdowns, yield blocks and latch holds are clear and no warp counts as last granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_vld_i | input | N | Oldest instruction present, per warp |
| dep_rdy_i | input | N | Dependence tracker reports no hazard, per warp |
| stall_i | input | N*4 | Stall field of each warp's oldest instruction |
| yield_i | input | N | Yield hint of each warp's oldest instruction |
| unit_i | input | N*2 | Target execution unit code, per warp |
| half_i | input | N | Target unit is half-warp wide (1) or full-warp wide (0) |
| cc_hit_i | input | N | Constant operand available (hit, or no constant operand) |
| grant_o | output | N | One-hot issue grant |
| grant_vld_o | output | 1 | An instruction issues this cycle |
| grant_idx_o | output | 3 | Index of the granted warp |

## Verification
The hardest state to reach from the ports is the forced switch after a long constant-cache miss. It needs one warp that stays preferred and keeps missing for four straight cycles, and at the same time a different warp that is ready and hits. Random inputs almost never hold those conditions for that long. A directed sequence therefore pins one warp's hit input low while a lower-numbered warp stays ready. It then drops the lower warp so the missing warp is picked again and the wait count restarts. It ends by restoring the hit. A reference model in the bench predicts every cycle of both the directed sequences and several thousand seeded random cycles.

// File: rtl/gty_pkg.sv
package gty_pkg;

    // Width class of an execution unit input latch.
    typedef enum logic {
        LANE_FULL = 1'b0,
        LANE_HALF = 1'b1
    } lane_width_e;

    // Which candidate the selector grants this cycle.
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_CAND = 2'd1,
        PICK_ALT  = 2'd2
    } pick_kind_e;

endpackage

// File: rtl/gty_youngest.sv
module gty_youngest #(
    parameter int unsigned N = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Highest set index wins: later iterations overwrite earlier ones.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/gty_stall_bank.sv
module gty_stall_bank #(
    parameter int unsigned N  = 8,
    parameter int unsigned SW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [IW-1:0] issue_idx_i,
    input  logic [SW-1:0] issue_stall_i,
    input  logic          issue_yield_i,
    output logic [N-1:0]  blocked_o
);

    typedef struct packed {
        logic [N-1:0][SW-1:0] cnt;
        logic [N-1:0]         yld;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.yld = '0;
        for (int w = 0; w < N; w++) begin
            if (b_q.cnt[w] != '0) begin
                b_d.cnt[w] = b_q.cnt[w] - SW'(1);
            end
        end
        if (issue_i) begin
            b_d.cnt[issue_idx_i] = (issue_stall_i == '0) ? '0 : issue_stall_i - SW'(1);
            b_d.yld[issue_idx_i] = issue_yield_i && (issue_stall_i <= SW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        for (int w = 0; w < N; w++) begin
            blocked_o[w] = (b_q.cnt[w] != '0) || b_q.yld[w];
        end
    end

    for (genvar w = 0; w < N; w++) begin : g_chk
        a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (b_q.cnt[w] != '0 && !(issue_i && issue_idx_i == IW'(w)))
            |=> (b_q.cnt[w] == $past(b_q.cnt[w]) - SW'(1)));
    end

    a_r6_yield_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && issue_yield_i && issue_stall_i <= SW'(1))
        |=> blocked_o[$past(issue_idx_i)]);

    a_r7_yield_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && issue_stall_i > SW'(1)) |=> !b_q.yld[$past(issue_idx_i)]);

endmodule

// File: rtl/gty_latch_bank.sv
module gty_latch_bank
    import gty_pkg::*;
#(
    parameter int unsigned NU = 4,
    localparam int unsigned UW = (NU > 1) ? $clog2(NU) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [UW-1:0] issue_unit_i,
    input  logic          issue_half_i,
    output logic [NU-1:0] busy_o
);

    typedef struct packed {
        logic [NU-1:0] hold;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.hold = '0;
        if (issue_i && lane_width_e'(issue_half_i) == LANE_HALF) begin
            l_d.hold[issue_unit_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign busy_o = l_q.hold;

    for (genvar u = 0; u < NU; u++) begin : g_chk
        a_r8_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_i && issue_half_i && issue_unit_i == UW'(u)) |=> busy_o[u]);
        a_r8_releases: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o[u] && !(issue_i && issue_half_i && issue_unit_i == UW'(u)))
            |=> !busy_o[u]);
    end

endmodule

// File: rtl/gty_issue_select.sv
module gty_issue_select
    import gty_pkg::*;
#(
    parameter int unsigned N        = 8,
    parameter int unsigned SW       = 4,
    parameter int unsigned NU       = 4,
    parameter int unsigned CC_LIMIT = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned UW = (NU > 1) ? $clog2(NU) : 1,
    localparam int unsigned CW = $clog2(CC_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    inst_vld_i,
    input  logic [N-1:0]    dep_rdy_i,
    input  logic [N*SW-1:0] stall_i,
    input  logic [N-1:0]    yield_i,
    input  logic [N*UW-1:0] unit_i,
    input  logic [N-1:0]    half_i,
    input  logic [N-1:0]    cc_hit_i,
    output logic [N-1:0]    grant_o,
    output logic            grant_vld_o,
    output logic [IW-1:0]   grant_idx_o
);

    typedef struct packed {
        logic          last_vld;
        logic [IW-1:0] last_idx;
        logic [CW-1:0] cc_cnt;
        logic [IW-1:0] cc_warp;
    } sel_t;

    sel_t s_d, s_q;

    logic [N-1:0]  blocked;
    logic [NU-1:0] busy;
    logic [UW-1:0] unit_w [N];
    logic [N-1:0]  ready;
    logic          y_found;
    logic [IW-1:0] y_idx;
    logic [N-1:0]  alt_req;
    logic          a_found;
    logic [IW-1:0] a_idx;
    logic          cand_vld;
    logic [IW-1:0] cand_idx;
    pick_kind_e    kind;
    logic          iss;
    logic [IW-1:0] iss_idx;
    logic [SW-1:0] iss_stall;
    logic [UW-1:0] iss_unit;

    for (genvar w = 0; w < N; w++) begin : g_unit
        assign unit_w[w] = unit_i[w*UW +: UW];
    end

    always_comb begin
        for (int w = 0; w < N; w++) begin
            ready[w] = inst_vld_i[w] && dep_rdy_i[w] && !blocked[w] && !busy[unit_w[w]];
        end
    end

    gty_youngest #(.N(N)) i_pick_all (
        .req_i   (ready),
        .found_o (y_found),
        .idx_o   (y_idx)
    );

    always_comb begin
        if (s_q.last_vld && ready[s_q.last_idx]) begin
            cand_vld = 1'b1;
            cand_idx = s_q.last_idx;
        end else begin
            cand_vld = y_found;
            cand_idx = y_idx;
        end
        alt_req           = ready & cc_hit_i;
        alt_req[cand_idx] = 1'b0;
    end

    gty_youngest #(.N(N)) i_pick_alt (
        .req_i   (alt_req),
        .found_o (a_found),
        .idx_o   (a_idx)
    );

    always_comb begin
        s_d  = s_q;
        kind = PICK_NONE;
        if (!cand_vld) begin
            s_d.cc_cnt = '0;
        end else if (cc_hit_i[cand_idx]) begin
            kind       = PICK_CAND;
            s_d.cc_cnt = '0;
        end else if (s_q.cc_cnt == CW'(CC_LIMIT) && s_q.cc_warp == cand_idx) begin
            if (a_found) begin
                kind       = PICK_ALT;
                s_d.cc_cnt = '0;
            end
        end else begin
            s_d.cc_warp = cand_idx;
            s_d.cc_cnt  = (s_q.cc_warp == cand_idx) ? s_q.cc_cnt + CW'(1) : CW'(1);
        end
        iss     = (kind != PICK_NONE);
        iss_idx = (kind == PICK_ALT) ? a_idx : cand_idx;
        if (iss) begin
            s_d.last_vld = 1'b1;
            s_d.last_idx = iss_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign iss_stall = stall_i[iss_idx*SW +: SW];
    assign iss_unit  = unit_w[iss_idx];

    gty_stall_bank #(.N(N), .SW(SW)) i_stall (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_i       (iss),
        .issue_idx_i   (iss_idx),
        .issue_stall_i (iss_stall),
        .issue_yield_i (yield_i[iss_idx]),
        .blocked_o     (blocked)
    );

    gty_latch_bank #(.NU(NU)) i_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (iss),
        .issue_unit_i (iss_unit),
        .issue_half_i (half_i[iss_idx]),
        .busy_o       (busy)
    );

    assign grant_vld_o = iss;
    assign grant_idx_o = iss ? iss_idx : '0;
    assign grant_o     = iss ? (N'(1) << iss_idx) : '0;

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    a_r1_index: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> grant_o[grant_idx_o]);

    a_r2_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> (inst_vld_i[grant_idx_o] && dep_rdy_i[grant_idx_o]));

    a_r3_greedy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.last_vld && ready[s_q.last_idx] && cc_hit_i[s_q.last_idx])
        |-> (grant_vld_o && grant_idx_o == s_q.last_idx));

    a_r9_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_vld && !cc_hit_i[cand_idx] && s_q.cc_cnt < CW'(CC_LIMIT)) |-> !grant_vld_o);

    a_r10_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cc_cnt <= CW'(CC_LIMIT));

    a_r10_switch_hits: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> cc_hit_i[grant_idx_o]);

endmodule

// File: tb/test_gty_issue_select.sv
module test_gty_issue_select;

    localparam int N   = 8;
    localparam int SW  = 4;
    localparam int NU  = 4;
    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]    inst_vld, dep_rdy, yield, half, cc_hit;
    logic [N*SW-1:0] stall;
    logic [N*2-1:0]  unit;
    logic [N-1:0]    grant;
    logic            grant_vld;
    logic [2:0]      grant_idx;

    gty_issue_select i_gty_issue_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .inst_vld_i  (inst_vld),
        .dep_rdy_i   (dep_rdy),
        .stall_i     (stall),
        .yield_i     (yield),
        .unit_i      (unit),
        .half_i      (half),
        .cc_hit_i    (cc_hit),
        .grant_o     (grant),
        .grant_vld_o (grant_vld),
        .grant_idx_o (grant_idx)
    );

    // staged stimulus, applied at the next falling edge
    bit s_vld[N], s_dep[N], s_yld[N], s_half[N], s_cc[N];
    int s_stall[N], s_unit[N];

    // reference model state
    int m_cnt[N];
    bit m_yblk[N];
    bit m_busy[NU];
    bit m_last_vld;
    int m_last, m_ccc, m_ccw;

    int vectors = 0;
    int miscompares = 0;

    task automatic model_reset();
        for (int w = 0; w < N; w++) begin m_cnt[w] = 0; m_yblk[w] = 0; end
        for (int u = 0; u < NU; u++) m_busy[u] = 0;
        m_last_vld = 0; m_last = 0; m_ccc = 0; m_ccw = 0;
    endtask

    task automatic stage_clear();
        for (int w = 0; w < N; w++) begin
            s_vld[w] = 0; s_dep[w] = 1; s_yld[w] = 0; s_half[w] = 0; s_cc[w] = 1;
            s_stall[w] = 0; s_unit[w] = w % NU;
        end
    endtask

    function automatic int youngest(input bit req[N], input int skip);
        int r = -1;
        for (int w = 0; w < N; w++) if (req[w] && w != skip) r = w;
        return r;
    endfunction

    task automatic step(input string tag);
        bit rdy[N], ok[N];
        int cand, alt, pick;
        logic [N-1:0] exp_g;
        @(negedge clk);
        for (int w = 0; w < N; w++) begin
            inst_vld[w] = s_vld[w]; dep_rdy[w] = s_dep[w]; yield[w] = s_yld[w];
            half[w] = s_half[w]; cc_hit[w] = s_cc[w];
            stall[w*SW +: SW] = SW'(s_stall[w]); unit[w*2 +: 2] = 2'(s_unit[w]);
        end
        #1;
        for (int w = 0; w < N; w++) begin
            rdy[w] = s_vld[w] && s_dep[w] && m_cnt[w] == 0 && !m_yblk[w] && !m_busy[s_unit[w]];
            ok[w]  = rdy[w] && s_cc[w];
        end
        if (m_last_vld && rdy[m_last]) cand = m_last; else cand = youngest(rdy, -1);
        pick = -1;
        if (cand < 0) m_ccc = 0;
        else if (s_cc[cand]) begin pick = cand; m_ccc = 0; end
        else if (m_ccc == LIM && m_ccw == cand) begin
            alt = youngest(ok, cand);
            if (alt >= 0) begin pick = alt; m_ccc = 0; end
        end else begin
            m_ccc = (m_ccw == cand) ? m_ccc + 1 : 1;
            m_ccw = cand;
        end
        exp_g = (pick >= 0) ? (N'(1) << pick) : '0;
        vectors++;
        if (grant !== exp_g || grant_vld !== (pick >= 0) ||
            grant_idx !== 3'((pick >= 0) ? pick : 0)) begin
            miscompares++;
            $display("FAIL %s: actual grant=%b vld=%0b idx=%0d expected grant=%b vld=%0b idx=%0d",
                     tag, grant, grant_vld, grant_idx, exp_g, pick >= 0, (pick >= 0) ? pick : 0);
        end
        // model next state
        for (int w = 0; w < N; w++) begin
            if (m_cnt[w] > 0) m_cnt[w]--;
            m_yblk[w] = 0;
        end
        for (int u = 0; u < NU; u++) m_busy[u] = 0;
        if (pick >= 0) begin
            m_cnt[pick] = (s_stall[pick] == 0) ? 0 : s_stall[pick] - 1;
            m_yblk[pick] = s_yld[pick] && s_stall[pick] <= 1;
            if (s_half[pick]) m_busy[s_unit[pick]] = 1;
            m_last_vld = 1; m_last = pick;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R1: actual run still busy expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h0005eed7));
        inst_vld = '0; dep_rdy = '0; yield = '0; half = '0; cc_hit = '0; stall = '0; unit = '0;
        model_reset();
        stage_clear();
        // R11: reset state, nothing valid
        step("R11 reset");
        rst_n = 1'b1;
        step("R11 after reset");

        // R4 first grant youngest, R3 greedy
        for (int w = 0; w < N; w++) s_vld[w] = 1;
        step("R4 first grant");
        step("R3 greedy");
        s_vld[7] = 0;
        step("R4 switch youngest");
        s_vld[7] = 1;
        step("R3 stays despite younger");
        step("R3 stays");

        // R2 dependence / valid gating
        stage_clear();
        s_vld[7] = 1; s_dep[7] = 0; s_vld[4] = 1;
        step("R2 dep not ready");
        s_vld[4] = 0;
        step("R2 nothing eligible");

        // R5 stall countdown
        stage_clear();
        s_vld[2] = 1; s_stall[2] = 4;
        for (int i = 0; i < 6; i++) step("R5 stall 4");
        s_stall[2] = 1;
        for (int i = 0; i < 3; i++) step("R5 stall 1");
        s_stall[2] = 15;
        for (int i = 0; i < 17; i++) step("R5 stall 15");

        // R6 yield, alone then with a partner
        stage_clear();
        s_vld[3] = 1; s_yld[3] = 1;
        for (int i = 0; i < 4; i++) step("R6 yield bubble");
        s_vld[1] = 1;
        for (int i = 0; i < 4; i++) step("R6 yield switch");

        // R7 yield ignored with stall 2
        stage_clear();
        s_vld[3] = 1; s_yld[3] = 1; s_stall[3] = 2;
        for (int i = 0; i < 5; i++) step("R7 yield with stall 2");
        s_yld[3] = 0;
        for (int i = 0; i < 4; i++) step("R7 stall 2 no yield");

        // R8 half-wide latch hold
        stage_clear();
        s_vld[5] = 1; s_vld[4] = 1; s_unit[5] = 0; s_unit[4] = 0;
        s_half[5] = 1; s_half[4] = 1;
        for (int i = 0; i < 4; i++) step("R8 same half unit");
        s_unit[4] = 1;
        for (int i = 0; i < 4; i++) step("R8 other unit");
        s_half[5] = 0; s_half[4] = 0; s_unit[4] = 0;
        for (int i = 0; i < 3; i++) step("R8 full width");

        // R9 / R10 constant miss wait and forced switch
        stage_clear();
        s_vld[6] = 1; s_vld[2] = 1; s_cc[6] = 0;
        for (int i = 0; i < 4; i++) step("R9 miss bubble");
        step("R10 switch away");
        step("R10 stays on alternate");
        s_vld[2] = 0;
        for (int i = 0; i < 5; i++) step("R9 miss restart");
        s_cc[6] = 1;
        step("R9 miss served");

        // random mix
        for (int c = 0; c < 4000; c++) begin
            for (int w = 0; w < N; w++) begin
                s_vld[w]   = ($urandom % 4) != 0;
                s_dep[w]   = ($urandom % 8) != 0;
                s_stall[w] = (($urandom % 4) == 0) ? int'($urandom % 6) : int'($urandom % 2);
                s_yld[w]   = ($urandom % 6) == 0;
                s_unit[w]  = int'($urandom % NU);
                s_half[w]  = ($urandom % 3) == 0;
                s_cc[w]    = ($urandom % 10) != 0;
            end
            step("R1 R3 R4 R10 random");
        end

        summary();
        $finish;
    end

endmodule